// File: doc/BRIEF.md
# Stall-Time Fair DRAM Request Picker

This block chooses which queued DRAM request a shared memory controller should issue next, when several hardware threads share the controller. Requests are written into a small buffer. Each request carries a thread number, a bank, a row and an age value, where a larger age means an older request. Every cycle the block offers exactly one candidate entry. The controller accepts it by raising `cmd_rdy`, and the block frees that entry at the same clock edge.

For each thread the block keeps a count of the cycles the thread has spent waiting on DRAM. It also holds an externally supplied estimate of the stall time the thread would see if it ran alone. The ratio of the two is the thread's slowdown. The ratio of the largest to the smallest slowdown among threads with queued requests is the system unfairness. While unfairness stays below a programmable threshold, the block maximises throughput: row hits go first, then older requests. Once unfairness reaches the threshold, the requests of the most slowed-down thread go to the front.

Top module: `stf_dram_picker`

## Requirements
- R1: After reset the buffer is empty, `pick_valid` is 0, all wait counters and alone estimates are zero, and the threshold holds its reset value of 24 (1.5).
- R2: An insert lands in the lowest-numbered free entry. When all entries are occupied, the insert is dropped and the buffer contents are unchanged.
- R3: `pick_valid` is 1 exactly when at least one entry is occupied, and `pick_idx` always names an occupied entry.
- R4: An entry counts as a row hit only when its bank's `open_vld` bit is 1 and its row equals that bank's `open_row` slice (bank b occupies bits b*ROWW upward).
- R5: In throughput mode the pick is the row hit with the greatest age. If there are no hits, it is the entry with the greatest age.
- R6: In fairness mode, entries of the thread with the largest slowdown rank first, then row hits, then greatest age. Slowdown is the wait count divided by the alone estimate.
- R7: Fairness mode applies when max slowdown / min slowdown >= threshold/16. The threshold has 4 fractional bits. A wait count or alone estimate of zero is used as one.
- R8: When fewer than two threads have queued entries, throughput mode is used whatever the threshold.
- R9: A thread's wait counter increments by one in every cycle in which it has at least one queued entry, and saturates at its maximum value. Otherwise it holds.
- R10: Ties left after all priority levels go to the lowest entry index.
- R11: At most one entry is taken per cycle. When `cmd_rdy` is 1 the picked entry is freed at that clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ins_valid | input | 1 | Write a new request this cycle |
| ins_tid | input | $clog2(NTHR) | Thread of the new request |
| ins_bank | input | $clog2(NBANK) | Bank of the new request |
| ins_row | input | ROWW | Row of the new request |
| ins_age | input | AGEW | Age of the new request, larger is older |
| open_vld | input | NBANK | Per-bank open-row present flag |
| open_row | input | NBANK*ROWW | Per-bank open row, bank b at bits b*ROWW upward |
| est_we | input | 1 | Write an alone-time estimate |
| est_tid | input | $clog2(NTHR) | Thread whose estimate is written |
| est_val | input | STW | Alone stall-time estimate |
| thr_we | input | 1 | Write the unfairness threshold |
| thr_val | input | THW | Threshold, fixed point with 4 fraction bits |
| cmd_rdy | input | 1 | Controller takes the current pick |
| pick_valid | output | 1 | A candidate is offered |
| pick_idx | output | $clog2(NENT) | Buffer entry of the candidate |
| pick_tid | output | $clog2(NTHR) | Thread of the candidate |
| pick_bank | output | $clog2(NBANK) | Bank of the candidate |
| pick_row | output | ROWW | Row of the candidate |

## Verification
The pick is combinational from the stored state, so a wrong wait count, a stale estimate or a bad threshold register shows up at `pick_idx` in the first cycle after the faulty update. It appears as a flip between a row-hit winner and a slowed-thread winner. The bench therefore builds cases in which the two policies disagree, and it times each check to the exact cycle when the wait counters cross the threshold ratio, including the case where the ratio equals the threshold exactly. A lost or doubled free is visible one cycle after a take, as a repeated index or a wrong slot for the next insert.

// File: rtl/stf_dram_picker.sv
module stf_dram_picker #(
  parameter int NTHR    = 4,
  parameter int NENT    = 8,
  parameter int NBANK   = 4,
  parameter int ROWW    = 8,
  parameter int AGEW    = 8,
  parameter int STW     = 16,
  parameter int THW     = 8,
  parameter int THR_RST = 24
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       ins_valid,
  input  logic [$clog2(NTHR)-1:0]    ins_tid,
  input  logic [$clog2(NBANK)-1:0]   ins_bank,
  input  logic [ROWW-1:0]            ins_row,
  input  logic [AGEW-1:0]            ins_age,
  input  logic [NBANK-1:0]           open_vld,
  input  logic [NBANK*ROWW-1:0]      open_row,
  input  logic                       est_we,
  input  logic [$clog2(NTHR)-1:0]    est_tid,
  input  logic [STW-1:0]             est_val,
  input  logic                       thr_we,
  input  logic [THW-1:0]             thr_val,
  input  logic                       cmd_rdy,
  output logic                       pick_valid,
  output logic [$clog2(NENT)-1:0]    pick_idx,
  output logic [$clog2(NTHR)-1:0]    pick_tid,
  output logic [$clog2(NBANK)-1:0]   pick_bank,
  output logic [ROWW-1:0]            pick_row
);
  localparam int TIDW = $clog2(NTHR);
  localparam int IDXW = $clog2(NENT);
  localparam int BKW  = $clog2(NBANK);
  localparam int PW   = 2 * STW;
  localparam int UW   = PW + THW;
  localparam int FRAC = 4;
  localparam int KW   = 2 + AGEW;

  logic [NENT-1:0]                vld;
  logic [NENT-1:0][TIDW-1:0]      e_tid;
  logic [NENT-1:0][BKW-1:0]       e_bank;
  logic [NENT-1:0][ROWW-1:0]      e_row;
  logic [NENT-1:0][AGEW-1:0]      e_age;
  logic [NTHR-1:0][STW-1:0]       sh;
  logic [NTHR-1:0][STW-1:0]       al;
  logic [THW-1:0]                 thr;

  logic [NTHR-1:0]                pend;
  logic [NTHR-1:0][STW-1:0]       ss, aa;
  logic [TIDW-1:0]                mx, mn;
  logic                           multi, fair;
  logic [UW-1:0]                  lhs, rhs;
  logic [NENT-1:0]                hit;
  logic                           have_free;
  logic [IDXW-1:0]                free_idx;
  logic                           take;

  function automatic logic [PW-1:0] mulx(input logic [STW-1:0] a, input logic [STW-1:0] b);
    return PW'(a) * PW'(b);
  endfunction

  always_comb begin
    pend = '0;
    for (int i = 0; i < NENT; i++)
      if (vld[i]) pend[e_tid[i]] = 1'b1;
    for (int t = 0; t < NTHR; t++) begin
      ss[t] = (sh[t] == '0) ? STW'(1) : sh[t];
      aa[t] = (al[t] == '0) ? STW'(1) : al[t];
    end
  end

  always_comb begin
    logic seen;
    seen  = 1'b0;
    multi = 1'b0;
    mx    = '0;
    mn    = '0;
    for (int t = 0; t < NTHR; t++) begin
      if (pend[t]) begin
        if (!seen) begin
          seen = 1'b1;
          mx   = TIDW'(t);
          mn   = TIDW'(t);
        end else begin
          multi = 1'b1;
          if (mulx(ss[t], aa[mx]) > mulx(ss[mx], aa[t])) mx = TIDW'(t);
          if (mulx(ss[t], aa[mn]) < mulx(ss[mn], aa[t])) mn = TIDW'(t);
        end
      end
    end
  end

  assign lhs  = UW'(mulx(ss[mx], aa[mn])) << FRAC;
  assign rhs  = UW'(mulx(aa[mx], ss[mn])) * UW'(thr);
  assign fair = multi && (lhs >= rhs);

  genvar g;
  generate
    for (g = 0; g < NENT; g++) begin : g_hit
      assign hit[g] = open_vld[e_bank[g]] &&
                      (open_row[e_bank[g]*ROWW +: ROWW] == e_row[g]);
    end
  endgenerate

  always_comb begin
    logic [KW-1:0] best, key;
    pick_valid = 1'b0;
    pick_idx   = '0;
    best       = '0;
    for (int i = 0; i < NENT; i++) begin
      key = {fair && (e_tid[i] == mx), hit[i], e_age[i]};
      if (vld[i] && (!pick_valid || key > best)) begin
        pick_valid = 1'b1;
        pick_idx   = IDXW'(i);
        best       = key;
      end
    end
  end

  assign pick_tid  = e_tid[pick_idx];
  assign pick_bank = e_bank[pick_idx];
  assign pick_row  = e_row[pick_idx];
  assign take      = pick_valid && cmd_rdy;

  always_comb begin
    have_free = 1'b0;
    free_idx  = '0;
    for (int i = NENT - 1; i >= 0; i--)
      if (!vld[i]) begin
        have_free = 1'b1;
        free_idx  = IDXW'(i);
      end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld    <= '0;
      e_tid  <= '0;
      e_bank <= '0;
      e_row  <= '0;
      e_age  <= '0;
      sh     <= '0;
      al     <= '0;
      thr    <= THW'(THR_RST);
    end else begin
      if (take) vld[pick_idx] <= 1'b0;
      if (ins_valid && have_free) begin
        vld[free_idx]    <= 1'b1;
        e_tid[free_idx]  <= ins_tid;
        e_bank[free_idx] <= ins_bank;
        e_row[free_idx]  <= ins_row;
        e_age[free_idx]  <= ins_age;
      end
      for (int t = 0; t < NTHR; t++)
        if (pend[t] && (sh[t] != '1)) sh[t] <= sh[t] + 1'b1;
      if (est_we) al[est_tid] <= est_val;
      if (thr_we) thr <= thr_val;
    end
  end
endmodule

// File: rtl/stf_dram_picker_chk.sv
module stf_dram_picker_chk #(
  parameter int NTHR = 4,
  parameter int NENT = 8,
  parameter int STW  = 16
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic                            cmd_rdy,
  input logic                            pick_valid,
  input logic [$clog2(NENT)-1:0]         pick_idx,
  input logic [NENT-1:0]                 vld,
  input logic [NTHR-1:0]                 pend,
  input logic [NTHR-1:0][STW-1:0]        sh
);
  assert_pick_occupied_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pick_valid |-> vld[pick_idx]);

  assert_take_frees_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (pick_valid && cmd_rdy) |=> !vld[$past(pick_idx)]);

  assert_full_keeps_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (&vld && !(pick_valid && cmd_rdy)) |=> &vld);

  genvar t;
  generate
    for (t = 0; t < NTHR; t++) begin : g_thr
      assert_wait_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pend[t] && sh[t] != '1) |=> sh[t] == $past(sh[t]) + 1'b1);
      assert_wait_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!pend[t] || sh[t] == '1) |=> $stable(sh[t]));
    end
  endgenerate
endmodule

bind stf_dram_picker stf_dram_picker_chk #(.NTHR(NTHR), .NENT(NENT), .STW(STW)) chk_i (
  .clk(clk), .rst_n(rst_n), .cmd_rdy(cmd_rdy), .pick_valid(pick_valid),
  .pick_idx(pick_idx), .vld(vld), .pend(pend), .sh(sh)
);

// File: tb/stf_dram_picker_tb_top.sv
module stf_dram_picker_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ins_valid = 1'b0;
  logic [1:0]  ins_tid = '0;
  logic [1:0]  ins_bank = '0;
  logic [7:0]  ins_row = '0;
  logic [7:0]  ins_age = '0;
  logic [3:0]  open_vld = 4'hF;
  logic [31:0] open_row = {8'h13, 8'h12, 8'h11, 8'h10};
  logic        est_we = 1'b0;
  logic [1:0]  est_tid = '0;
  logic [15:0] est_val = '0;
  logic        thr_we = 1'b0;
  logic [7:0]  thr_val = '0;
  logic        cmd_rdy = 1'b0;
  logic        pick_valid;
  logic [2:0]  pick_idx;
  logic [1:0]  pick_tid;
  logic [1:0]  pick_bank;
  logic [7:0]  pick_row;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  stf_dram_picker dut_i (
    .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_tid(ins_tid),
    .ins_bank(ins_bank), .ins_row(ins_row), .ins_age(ins_age),
    .open_vld(open_vld), .open_row(open_row), .est_we(est_we),
    .est_tid(est_tid), .est_val(est_val), .thr_we(thr_we), .thr_val(thr_val),
    .cmd_rdy(cmd_rdy), .pick_valid(pick_valid), .pick_idx(pick_idx),
    .pick_tid(pick_tid), .pick_bank(pick_bank), .pick_row(pick_row)
  );

  // entry0 {tid,bank,row,age}, entry1 {tid,bank,row,age}, open_vld, expected idx
  localparam logic [44:0] VEC [6] = '{
    {2'd0, 2'd0, 8'h10, 8'd5, 2'd1, 2'd1, 8'h22, 8'd9, 4'hF, 1'b0},
    {2'd0, 2'd0, 8'h33, 8'd5, 2'd1, 2'd1, 8'h11, 8'd2, 4'hF, 1'b1},
    {2'd0, 2'd0, 8'h33, 8'd5, 2'd1, 2'd1, 8'h11, 8'd2, 4'hD, 1'b0},
    {2'd0, 2'd2, 8'h12, 8'd1, 2'd2, 2'd3, 8'h13, 8'd7, 4'hF, 1'b1},
    {2'd1, 2'd0, 8'h00, 8'd4, 2'd3, 2'd1, 8'h00, 8'd4, 4'hF, 1'b0},
    {2'd2, 2'd0, 8'h44, 8'd9, 2'd2, 2'd0, 8'h10, 8'd1, 4'h1, 1'b1}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    cmd_rdy = 1'b0;
    open_vld = 4'hF;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic ins(input int t, input int b, input int r, input int a);
    @(negedge clk);
    ins_valid = 1'b1;
    ins_tid = 2'(t); ins_bank = 2'(b); ins_row = 8'(r); ins_age = 8'(a);
    @(posedge clk);
    #1 ins_valid = 1'b0;
  endtask

  task automatic set_thr(input int v);
    @(negedge clk);
    thr_we = 1'b1; thr_val = 8'(v);
    @(posedge clk);
    #1 thr_we = 1'b0;
  endtask

  task automatic set_est(input int t, input int v);
    @(negedge clk);
    est_we = 1'b1; est_tid = 2'(t); est_val = 16'(v);
    @(posedge clk);
    #1 est_we = 1'b0;
  endtask

  task automatic take_one();
    @(negedge clk);
    cmd_rdy = 1'b1;
    @(posedge clk);
    #1 cmd_rdy = 1'b0;
  endtask

  // Two-thread race: thread0 miss young at slot0, thread1 hit old at slot1.
  task automatic race(input int thr, input int waits, input int exp, input string req);
    do_reset();
    set_thr(thr);
    ins(0, 0, 8'h55, 1);
    ins(1, 1, 8'h11, 9);
    for (int k = 0; k < waits; k++) @(posedge clk);
    @(negedge clk);
    chk(req, pick_idx, exp);
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    // R1 reset state
    do_reset();
    @(negedge clk);
    chk("R1 pick_valid after reset", pick_valid, 0);

    // Table: throughput mode, R4 R5 R10
    for (int v = 0; v < 6; v++) begin
      logic [44:0] w;
      w = VEC[v];
      do_reset();
      open_vld = w[4:1];
      ins(w[44:43], w[42:41], w[40:33], w[32:25]);
      ins(w[24:23], w[22:21], w[20:13], w[12:5]);
      @(negedge clk);
      chk($sformatf("R5 R4 R10 vector %0d", v), pick_idx, w[0]);
    end

    // R7 exact ratio 2.0 at threshold 2.0 -> fairness mode, thread0 first (R6)
    race(32, 1, 0, "R7 R6 ratio equals threshold");
    race(33, 1, 1, "R7 ratio below threshold");
    // R7 zero counter floor: ratio 1/1 vs threshold 1.0
    race(16, 0, 0, "R7 zero count as one");
    race(17, 0, 1, "R7 zero count below threshold");

    // R6 alone estimate makes thread1 the slowed one
    do_reset();
    set_est(0, 8);
    ins(0, 1, 8'h11, 9);
    ins(1, 0, 8'h55, 1);
    for (int k = 0; k < 3; k++) @(posedge clk);
    @(negedge clk);
    chk("R6 max slowdown thread first", pick_idx, 1);
    chk("R6 picked thread", pick_tid, 1);

    // R8 single thread with threshold 0 stays in throughput mode
    do_reset();
    set_thr(0);
    ins(2, 0, 8'h55, 9);
    ins(2, 1, 8'h11, 1);
    @(negedge clk);
    chk("R8 single thread throughput", pick_idx, 1);

    // R11 take and free, R2 reuse of lowest free slot
    do_reset();
    ins(0, 0, 8'h55, 9);
    ins(0, 1, 8'h11, 1);
    take_one();
    @(negedge clk);
    chk("R11 remaining entry after take", pick_idx, 0);
    chk("R3 still valid", pick_valid, 1);
    ins(0, 1, 8'h11, 0);
    @(negedge clk);
    chk("R2 insert reuses freed slot", pick_idx, 1);
    take_one();
    take_one();
    @(negedge clk);
    chk("R3 empty after takes", pick_valid, 0);

    // R2 full buffer drops insert
    do_reset();
    for (int i = 0; i < 8; i++) ins(0, 0, 8'h55, 10 + i);
    ins(0, 1, 8'h11, 255);
    @(negedge clk);
    chk("R2 full drop idx", pick_idx, 7);
    chk("R2 full drop row", pick_row, 8'h55);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule